// File: doc/BRIEF.md
# Trinary Pulse-Pair Serial Encoder

This block turns nine three-state digits into a single serial line for a remote-control link. Each digit reaches the block as a 2-bit state code: low, high or open. The open state is detected by circuitry upstream. Every digit goes out as a pair of pulses. A pulse is short or long, and each pulse starts at the beginning of a fixed slot of clocks. The pair of widths tells the receiver which of the three states was sent.

An active-low enable starts an encoding sequence. The sequence sends the nine-digit word, stays low for a dead time of three data periods, sends the word again and then stays low for the same dead time. If enable is still low when that second dead time ends, the next sequence starts at once, so a held enable gives an unbroken stream. A short low pulse gives exactly one sequence, and the line then stays low until enable is driven low again. The digit inputs are captured at the start of each word.

Top module: `trienc_top`

## Requirements
- R1: While reset is asserted, and afterwards while enable has not been driven low, `serOut` is low.
- R2: A digit with state code 2'b00 (low) is sent as two short pulses. A short pulse is high for SHORT_CLKS (1) clocks.
- R3: A digit with state code 2'b01 (high) is sent as two long pulses. A long pulse is high for LONG_CLKS (3) clocks.
- R4: A digit with state code 2'b10 or 2'b11 (open) is sent as a long pulse followed by a short pulse.
- R5: Each pulse starts at the beginning of its own slot of SLOT_CLKS (4) clocks and the line is low for the rest of the slot. A digit takes two slots. Digit 1 (`digitsIn[1:0]`) goes first and digit 9 (`digitsIn[17:16]`) goes last.
- R6: After the last slot of the first word, the line stays low for GAP_PERIODS data periods (3 x 8 = 24 clocks). The second word starts after that gap.
- R7: Enable is active low and sampled on the rising clock edge while the block is idle. The first pulse of the first word appears on `serOut` one clock after the edge that samples enable low.
- R8: If enable is low when the 24-clock gap after the second word ends, a new sequence starts with no extra clock. Its first pulse follows the same gap as the one between two words.
- R9: Once started, a sequence always sends both words and its trailing gap, whatever enable does. If enable is high when the trailing gap ends, the line stays low and no further pulse appears.
- R10: The digit inputs are captured when each word starts. A change during a word only shows in the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; all timing counts its rising edges |
| rstN | input | 1 | Active-low synchronous reset |
| txEnN | input | 1 | Active-low transmit enable |
| digitsIn | input | 2*NUM_DIGITS | Digit state codes, digit 1 in the lowest two bits |
| serOut | output | 1 | Registered pulse-coded serial output |

## Verification
The bench uses the default parameters: nine digits, 4-clock slots, 1-clock and 3-clock pulses and a three-period gap. With these values a full sequence lasts 192 clocks. A single pulse, a long-held enable and three back-to-back sequences therefore all run within a few thousand cycles. The mix of state codes in the test words, including the alternate open code 2'b11, exercises every pulse-pair combination. The short sequence length also makes it cheap to change the digit inputs in the middle of a word and check that only the next word shows the change.

// File: rtl/trienc_pkg.sv
package trienc_pkg;

  // 2-bit digit state code presented by the upstream sensing logic
  typedef enum logic [1:0] {
    DIG_LOW      = 2'b00,
    DIG_HIGH     = 2'b01,
    DIG_OPEN     = 2'b10,
    DIG_OPEN_ALT = 2'b11
  } digit_e;

  // sequencing state of the control unit
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WORD = 2'b01,
    ST_GAP  = 2'b10
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;     // capture the digit inputs on this edge
    logic inWord;       // a word is being sent this cycle
    logic secondPulse;  // current slot is the second of the digit
    logic digitEnd;     // last clock of the digit's second slot
    logic shortOn;      // slot phase lies inside a short pulse
    logic longOn;       // slot phase lies inside a long pulse
  } txStrobe_t;

endpackage

// File: rtl/trienc_ctrl.sv
module trienc_ctrl
  import trienc_pkg::*;
#(
  parameter int NUM_DIGITS  = 9,
  parameter int SLOT_CLKS   = 4,
  parameter int SHORT_CLKS  = 1,
  parameter int LONG_CLKS   = 3,
  parameter int GAP_PERIODS = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnN,
  output txStrobe_t strb
);

  localparam int NUM_SLOTS = 2 * NUM_DIGITS;
  localparam int GAP_CLKS  = GAP_PERIODS * 2 * SLOT_CLKS;
  localparam int PHW       = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam int SLOTW     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int GAPW      = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;

  localparam logic [PHW-1:0]   PH_LAST    = PHW'(SLOT_CLKS - 1);
  localparam logic [SLOTW-1:0] SLOT_LAST  = SLOTW'(NUM_SLOTS - 1);
  localparam logic [GAPW-1:0]  GAP_LAST   = GAPW'(GAP_CLKS - 1);
  localparam logic [PHW:0]     SHORT_LIM  = (PHW + 1)'(SHORT_CLKS);
  localparam logic [PHW:0]     LONG_LIM   = (PHW + 1)'(LONG_CLKS);

  txState_e         state;
  logic [PHW-1:0]   phase;
  logic [SLOTW-1:0] slotCnt;
  logic [GAPW-1:0]  gapCnt;
  logic             secondWord;

  logic slotEnd, wordEnd, gapEnd, startWord;

  always_comb begin
    slotEnd   = (state == ST_WORD) && (phase == PH_LAST);
    wordEnd   = slotEnd && (slotCnt == SLOT_LAST);
    gapEnd    = (state == ST_GAP) && (gapCnt == GAP_LAST);
    // after the first word the second always follows; after the second
    // a new sequence follows only while enable is still low
    startWord = ((state == ST_IDLE) && !txEnN) ||
                (gapEnd && (!secondWord || !txEnN));
  end

  always_comb begin
    strb.loadWord    = startWord;
    strb.inWord      = (state == ST_WORD);
    strb.secondPulse = slotCnt[0];
    strb.digitEnd    = slotEnd && slotCnt[0];
    strb.shortOn     = ({1'b0, phase} < SHORT_LIM);
    strb.longOn      = ({1'b0, phase} < LONG_LIM);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= '0;
      slotCnt    <= '0;
      gapCnt     <= '0;
      secondWord <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startWord) begin
            state      <= ST_WORD;
            phase      <= '0;
            slotCnt    <= '0;
            secondWord <= 1'b0;
          end
        end
        ST_WORD: begin
          if (slotEnd) begin
            phase   <= '0;
            slotCnt <= slotCnt + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
          if (wordEnd) begin
            state   <= ST_GAP;
            gapCnt  <= '0;
            slotCnt <= '0;
          end
        end
        ST_GAP: begin
          gapCnt <= gapCnt + 1'b1;
          if (gapEnd) begin
            gapCnt <= '0;
            if (startWord) begin
              state      <= ST_WORD;
              phase      <= '0;
              slotCnt    <= '0;
              secondWord <= !secondWord;
            end else begin
              state      <= ST_IDLE;
              secondWord <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/trienc_datapath.sv
module trienc_datapath
  import trienc_pkg::*;
#(
  parameter int NUM_DIGITS = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2*NUM_DIGITS-1:0] digitsIn,
  input  txStrobe_t               strb,
  output logic                    serOut
);

  localparam int WORDW = 2 * NUM_DIGITS;

  logic [WORDW-1:0] wordReg;
  digit_e           curDigit;
  logic             isLong;
  logic             pulseOn;

  // word register: loads all digits, then shifts one digit per digit time
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_stage
    logic [1:0] shiftIn;
    if (g == NUM_DIGITS - 1) begin : g_tail
      assign shiftIn = 2'b00;
    end else begin : g_link
      assign shiftIn = wordReg[2*g+2 +: 2];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wordReg[2*g +: 2] <= 2'b00;
      end else if (strb.loadWord) begin
        wordReg[2*g +: 2] <= digitsIn[2*g +: 2];
      end else if (strb.digitEnd) begin
        wordReg[2*g +: 2] <= shiftIn;
      end
    end
  end

  always_comb begin
    curDigit = digit_e'(wordReg[1:0]);
    if (strb.secondPulse) begin
      isLong = (curDigit == DIG_HIGH);
    end else begin
      isLong = (curDigit != DIG_LOW);
    end
    pulseOn = strb.inWord && (isLong ? strb.longOn : strb.shortOn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serOut <= 1'b0;
    end else begin
      serOut <= pulseOn;
    end
  end

endmodule

// File: rtl/trienc_top.sv
module trienc_top
  import trienc_pkg::*;
#(
  parameter int NUM_DIGITS  = 9,
  parameter int SLOT_CLKS   = 4,
  parameter int SHORT_CLKS  = 1,
  parameter int LONG_CLKS   = 3,
  parameter int GAP_PERIODS = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    txEnN,
  input  logic [2*NUM_DIGITS-1:0] digitsIn,
  output logic                    serOut
);

  txStrobe_t strb;

  trienc_ctrl #(
    .NUM_DIGITS (NUM_DIGITS),
    .SLOT_CLKS  (SLOT_CLKS),
    .SHORT_CLKS (SHORT_CLKS),
    .LONG_CLKS  (LONG_CLKS),
    .GAP_PERIODS(GAP_PERIODS)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .txEnN(txEnN),
    .strb (strb)
  );

  trienc_datapath #(
    .NUM_DIGITS(NUM_DIGITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .digitsIn(digitsIn),
    .strb    (strb),
    .serOut  (serOut)
  );

endmodule

// File: rtl/trienc_chk.sv
module trienc_chk #(
  parameter int SLOT_CLKS   = 4,
  parameter int LONG_CLKS   = 3,
  parameter int GAP_PERIODS = 3
) (
  input logic clk,
  input logic rstN,
  input logic serOut,
  input logic inWord,
  input logic loadWord
);

  localparam int GAP_CLKS = GAP_PERIODS * 2 * SLOT_CLKS;
  localparam int RUNW     = $clog2(LONG_CLKS + 2);
  localparam int GAPW     = $clog2(GAP_CLKS + 1);
  localparam logic [RUNW-1:0] RUN_MAX  = RUNW'(LONG_CLKS + 1);
  localparam logic [RUNW-1:0] LONG_LIM = RUNW'(LONG_CLKS);
  localparam logic [GAPW-1:0] GAP_LOAD = GAPW'(GAP_CLKS);

  logic [RUNW-1:0] highRun;
  logic [GAPW-1:0] gapLeft;
  logic            prevInWord;
  logic            wordFell;

  assign wordFell = prevInWord && !inWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highRun    <= '0;
      gapLeft    <= '0;
      prevInWord <= 1'b0;
    end else begin
      prevInWord <= inWord;
      if (!serOut) highRun <= '0;
      else if (highRun != RUN_MAX) highRun <= highRun + 1'b1;
      if (wordFell) gapLeft <= GAP_LOAD;
      else if (gapLeft != '0) gapLeft <= gapLeft - 1'b1;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !serOut);

  // no pulse may stay high longer than a long pulse
  assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    serOut |-> (highRun < LONG_LIM));

  // the output is only driven high by a word in progress one clock earlier
  assert_out_needs_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    serOut |-> prevInWord);

  assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wordFell || (gapLeft != '0)) |-> !serOut);

  assert_load_starts_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadWord |=> inWord);

endmodule

bind trienc_top trienc_chk #(
  .SLOT_CLKS  (SLOT_CLKS),
  .LONG_CLKS  (LONG_CLKS),
  .GAP_PERIODS(GAP_PERIODS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .serOut  (serOut),
  .inWord  (strb.inWord),
  .loadWord(strb.loadWord)
);

// File: tb/tb_trienc_top.sv
`timescale 1ns/1ps
module tb_trienc_top;

  localparam int N    = 9;
  localparam int SLOT = 4;
  localparam int GAPC = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          txEnN = 1'b1;
  logic [2*N-1:0] digitsIn = '0;
  logic          serOut;

  always #2.5 clk = ~clk;

  trienc_top dut (
    .clk(clk), .rstN(rstN), .txEnN(txEnN), .digitsIn(digitsIn), .serOut(serOut)
  );

  typedef struct {
    int    len;   // >0: high run, <0: low run
    string tag;
  } exp_t;

  exp_t  expQ[$];
  int    nTests = 0;
  int    nFail = 0;
  bit    skipLow = 1'b1;
  bit    prevOut = 1'b0;
  int    runLen = 0;
  int    riseCnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic compareNext(input int v);
    exp_t e;
    if (expQ.size() == 0) begin
      check(1'b0, "R9 unexpected run", v, 0);
    end else begin
      e = expQ.pop_front();
      check(e.len == v, e.tag, v, e.len);
    end
  endtask

  // monitor: measures run lengths of serOut and scores them
  always @(negedge clk) begin
    if (rstN) begin
      if (serOut && !prevOut) begin
        riseCnt++;
        if (skipLow) skipLow = 1'b0;
        else compareNext(-runLen);
        runLen = 1;
      end else if (!serOut && prevOut) begin
        compareNext(runLen);
        runLen = 1;
      end else begin
        runLen++;
      end
      prevOut = serOut;
    end
  end

  function automatic int pulseW(input logic [1:0] c, input bit second);
    if (c == 2'b00) return 1;
    if (c == 2'b01) return 3;
    return second ? 1 : 3;
  endfunction

  task automatic pushItem(input int len, input string tag);
    exp_t e;
    e.len = len;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // driver side of the scoreboard: expected runs for one word
  task automatic pushWord(input logic [2*N-1:0] w, input string pfx,
                          input string endTag, input bit more);
    for (int i = 0; i < N; i++) begin
      logic [1:0] c;
      int h1, h2;
      string tg;
      c  = w[2*i +: 2];
      h1 = pulseW(c, 1'b0);
      h2 = pulseW(c, 1'b1);
      if (c == 2'b00)      tg = {pfx, "R2 R5"};
      else if (c == 2'b01) tg = {pfx, "R3 R5"};
      else                 tg = {pfx, "R4 R5"};
      pushItem(h1, tg);
      pushItem(-(SLOT - h1), "R5 slot low");
      pushItem(h2, tg);
      if (i < N - 1) pushItem(-(SLOT - h2), "R5 slot low");
      else if (more) pushItem(-(SLOT - h2 + GAPC), endTag);
    end
  endtask

  // start from idle with a one-clock enable pulse and check the R7 latency
  task automatic startPulse();
    skipLow = 1'b1;
    @(posedge clk); #1 txEnN = 1'b0;
    @(posedge clk); #1 txEnN = 1'b1;
    @(negedge clk);
    check(serOut == 1'b0, "R7 latency early", serOut, 0);
    @(negedge clk);
    check(serOut == 1'b1, "R7 first pulse", serOut, 1);
  endtask

  task automatic checkQuiet(input int waitClks);
    int r;
    repeat (waitClks) @(posedge clk);
    check(expQ.size() == 0, "R9 sequence incomplete", expQ.size(), 0);
    r = riseCnt;
    repeat (100) @(posedge clk);
    @(negedge clk);
    check(riseCnt == r, "R9 pulse after sequence", riseCnt - r, 0);
    check(serOut == 1'b0, "R9 idle level", serOut, 0);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [2*N-1:0] wMix, wHigh, wLow, wAlt, wNew;
    // digit 1 in bits [1:0]
    wMix  = {2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b11, 2'b10, 2'b01, 2'b00};
    wHigh = {N{2'b01}};
    wLow  = {N{2'b00}};
    wAlt  = {2'b11, 2'b00, 2'b01, 2'b01, 2'b10, 2'b00, 2'b11, 2'b00, 2'b01};
    wNew  = {2'b01, 2'b10, 2'b00, 2'b00, 2'b11, 2'b01, 2'b00, 2'b10, 2'b10};

    // R1: reset state and idle after release
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(serOut == 1'b0, "R1 in reset", serOut, 0);
    @(posedge clk); #1 rstN = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(serOut == 1'b0, "R1 idle after reset", serOut, 0);
    check(riseCnt == 0, "R1 no pulse while idle", riseCnt, 0);

    // mixed word, one-clock enable pulse: R2 R3 R4 R5 R6 R7 R9
    digitsIn = wMix;
    pushWord(wMix, "", "R6 inter-word gap", 1'b1);
    pushWord(wMix, "", "", 1'b0);
    startPulse();
    checkQuiet(200);

    // all-high word, enable held low for 50 clocks then released mid-sequence
    digitsIn = wHigh;
    pushWord(wHigh, "", "R6 inter-word gap", 1'b1);
    pushWord(wHigh, "", "", 1'b0);
    skipLow = 1'b1;
    @(posedge clk); #1 txEnN = 1'b0;
    repeat (50) @(posedge clk);
    #1 txEnN = 1'b1;
    checkQuiet(160);

    // all-low word
    digitsIn = wLow;
    pushWord(wLow, "", "R6 inter-word gap", 1'b1);
    pushWord(wLow, "", "", 1'b0);
    startPulse();
    checkQuiet(200);

    // R10: inputs change during the first word, second word shows the change
    digitsIn = wAlt;
    pushWord(wAlt, "R10 ", "R6 inter-word gap", 1'b1);
    pushWord(wNew, "R10 ", "", 1'b0);
    startPulse();
    repeat (30) @(posedge clk);
    #1 digitsIn = wNew;
    checkQuiet(170);

    // R8: enable held low across three sequences
    digitsIn = wMix;
    pushWord(wMix, "", "R6 inter-word gap", 1'b1);
    pushWord(wMix, "", "R8 back-to-back gap", 1'b1);
    pushWord(wMix, "", "R6 inter-word gap", 1'b1);
    pushWord(wMix, "", "R8 back-to-back gap", 1'b1);
    pushWord(wMix, "", "R6 inter-word gap", 1'b1);
    pushWord(wMix, "", "", 1'b0);
    skipLow = 1'b1;
    @(posedge clk); #1 txEnN = 1'b0;
    repeat (400) @(posedge clk);
    #1 txEnN = 1'b1;
    checkQuiet(300);

    finishRun();
  end

endmodule